// File: doc/BRIEF.md
# Wishbone Register Bank Slave

This block is a register-bank slave on a pipelined Wishbone bus with 32-bit words. It holds a small set of registers of four kinds. A control word and a mode field can be written and read. A command word can only be written. A status word can only be read and shows an input port. An identity word is a constant. The bank also holds a 16-word RAM window inside the block. User logic sees the writable registers on output ports. It gets a one-cycle write strobe for the control and command registers, and it supplies the status value on an input port.

The bus master raises cyc and stb and holds the request until it sees ack. Every access is acknowledged, including an access that hits no register. A register access acks one cycle after the request. An unmapped read acks in the same cycle. A write into the RAM window takes one extra cycle, because the RAM write enable is issued before the ack. Stall is high while a request is up and not yet acknowledged.

Word address map, taken from adr[ADDR_W-1:2]: 0 is control, 1 is mode, 2 is command, 3 is status, 4 is identity, and RAM_BASE to RAM_BASE+15 is the RAM window (default base 16). All other word addresses are unmapped.

Top module: `wb_regbank`

## Requirements
- R1: While rst_ni is low, and after it is released, ctrl_o equals CTRL_PRESET (default 0x000000A5), mode_o and cmd_o are zero, both write strobes are low and wb_ack_o is low.
- R2: A write to control (word 0), mode (word 1, low 16 bits of data) or command (word 2) updates the matching output port at the first clock edge of the request. wb_ack_o rises after that edge. wb_stall_o is high and wb_ack_o is low in the request cycle before that edge.
- R3: If the master keeps a write request high after it is acknowledged, ack drops for one cycle and then rises again: the ack pattern is 1, 0, 1.
- R4: ctrl_wstb_o or cmd_wstb_o is high for exactly one cycle, in the cycle when its register's write ack is first visible.
- R5: A write to an unmapped word address is acknowledged one cycle after the request and leaves ctrl_o, mode_o and cmd_o unchanged.
- R6: A read of control, mode (zero-extended from 16 bits), status (the value of status_i) or identity (ID_VALUE, default 0x5EA10001) acks one cycle after the request with that data on wb_dat_o.
- R7: A read of the write-only command register acks one cycle after the request with all-zero data.
- R8: A read of an unmapped word address acks in the same cycle as the request with all-zero data.
- R9: A write into the RAM window acks two cycles after the request. A later read of the same word acks one cycle after the request and returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | 1 for write, 0 for read |
| wb_adr_i | input | ADDR_W | Byte address; word address is bits [ADDR_W-1:2] |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| wb_stall_o | output | 1 | Request pending, not yet acknowledged |
| ctrl_o | output | 32 | Control register value |
| ctrl_wstb_o | output | 1 | One-cycle pulse on a control write |
| mode_o | output | 16 | Mode field value |
| cmd_o | output | 32 | Command register value |
| cmd_wstb_o | output | 1 | One-cycle pulse on a command write |
| status_i | input | 32 | Value returned by the status register |

## Verification
The hardest case to reach is a write request that stays high after its ack. The write process then has to skip one cycle and run the same write again. A master that behaves well never does this, so the stimulus holds stb by hand across three sampling points and checks the ack and strobe pattern at each one. The two-step RAM write is similar: the data lands in the cycle between the write-enable issue and the ack. The stimulus therefore reads both ends of the window back after writing them, and the transfer task measures the exact ack latency for every access in the table.

// File: rtl/wb_regbank_pkg.sv
package wb_regbank_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned MODE_W  = 16;
  // word addresses of the register slots
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_MODE   = 1;
  localparam int unsigned W_CMD    = 2;
  localparam int unsigned W_STATUS = 3;
  localparam int unsigned W_ID     = 4;
  localparam int unsigned N_REGS   = 5;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/wb_regbank_front.sv
module wb_regbank_front
  import wb_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RAM_AW   = 4,
  parameter int unsigned RAM_BASE = 16,
  localparam int unsigned WA_W    = ADDR_W - 2
) (
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic            rd_ack_i,
  input  logic            wr_ack_i,
  output logic            rd_req_o,
  output logic            wr_req_o,
  output logic [WA_W-1:0] wadr_o,
  output logic            reg_hit_o,
  output logic            ram_sel_o,
  output logic            ack_o,
  output logic            stall_o
);
  logic en;
  logic unused_low_adr;

  assign en             = cyc_i & stb_i;
  assign rd_req_o       = en & ~we_i;
  assign wr_req_o       = en & we_i;
  assign wadr_o         = adr_i[ADDR_W-1:2];
  assign unused_low_adr = ^adr_i[1:0];
  assign reg_hit_o      = wadr_o < WA_W'(N_REGS);
  assign ram_sel_o      = wadr_o[WA_W-1:RAM_AW] == (WA_W-RAM_AW)'(RAM_BASE >> RAM_AW);
  assign ack_o          = rd_ack_i | wr_ack_i;
  assign stall_o        = en & ~ack_o;
endmodule

// File: rtl/wb_regbank_regs.sv
module wb_regbank_regs
  import wb_regbank_pkg::*;
#(
  parameter int unsigned WA_W        = 6,
  parameter word_t       CTRL_PRESET = 32'h0000_00A5,
  parameter word_t       ID_VALUE    = 32'h5EA1_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [WA_W-1:0]   wadr_i,
  input  logic              reg_hit_i,
  input  logic              ram_sel_i,
  input  word_t             wdata_i,
  input  word_t             status_i,
  output word_t             ctrl_o,
  output logic              ctrl_wstb_o,
  output logic [MODE_W-1:0] mode_o,
  output word_t             cmd_o,
  output logic              cmd_wstb_o,
  output logic              wr_ack_o,
  output logic              rd_ack1_o,
  output word_t             rd_dat_o,
  output logic              ram_we_o
);
  logic ram_dly;

  // write process: one execution per low-ack cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= CTRL_PRESET;
      mode_o      <= '0;
      cmd_o       <= '0;
      ctrl_wstb_o <= 1'b0;
      cmd_wstb_o  <= 1'b0;
      wr_ack_o    <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_dly     <= 1'b0;
    end else begin
      ctrl_wstb_o <= 1'b0;
      cmd_wstb_o  <= 1'b0;
      ram_we_o    <= 1'b0;
      if (wr_req_i && !wr_ack_o) begin
        if (ram_sel_i) begin
          if (!ram_dly) begin
            ram_we_o <= 1'b1;
            ram_dly  <= 1'b1;
          end else begin
            ram_dly  <= 1'b0;
            wr_ack_o <= 1'b1;
          end
        end else begin
          wr_ack_o <= 1'b1;
          case (wadr_i)
            WA_W'(W_CTRL): begin ctrl_o <= wdata_i; ctrl_wstb_o <= 1'b1; end
            WA_W'(W_MODE): mode_o <= wdata_i[MODE_W-1:0];
            WA_W'(W_CMD):  begin cmd_o <= wdata_i; cmd_wstb_o <= 1'b1; end
            default: ;
          endcase
        end
      end else begin
        wr_ack_o <= 1'b0;
        ram_dly  <= 1'b0;
      end
    end
  end

  // registered read path for the register slots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ack1_o <= 1'b0;
      rd_dat_o  <= '0;
    end else if (rd_req_i && !rd_ack1_o) begin
      rd_ack1_o <= 1'b1;
      case (wadr_i)
        WA_W'(W_CTRL):   rd_dat_o <= ctrl_o;
        WA_W'(W_MODE):   rd_dat_o <= DW'(mode_o);
        WA_W'(W_STATUS): rd_dat_o <= status_i;
        WA_W'(W_ID):     rd_dat_o <= ID_VALUE;
        default:         rd_dat_o <= '0;
      endcase
    end else begin
      rd_ack1_o <= 1'b0;
    end
  end

  // R2
  reg_write_acks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !wr_ack_o && !ram_sel_i |=> wr_ack_o);
  // R3
  ack_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |=> !wr_ack_o);
  // R4
  ctrl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wstb_o |=> !ctrl_wstb_o);
  // R4
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wstb_o |=> !cmd_wstb_o);
  // R5
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !wr_ack_o && !reg_hit_i && !ram_sel_i
      |=> $stable(ctrl_o) && $stable(mode_o) && $stable(cmd_o));
  // R6
  read_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && !rd_ack1_o |=> rd_ack1_o);
  // R9
  ram_write_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o && wr_req_i |=> wr_ack_o && !ram_we_o);
endmodule

// File: rtl/wb_regbank_ram.sv
module wb_regbank_ram
  import wb_regbank_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         wdata_i,
  output word_t         rdata_o
);
  word_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/wb_regbank.sv
module wb_regbank
  import wb_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned RAM_DEPTH   = 16,
  parameter int unsigned RAM_BASE    = 16,
  parameter logic [31:0] CTRL_PRESET = 32'h0000_00A5,
  parameter logic [31:0] ID_VALUE    = 32'h5EA1_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_stall_o,
  output logic [31:0]       ctrl_o,
  output logic              ctrl_wstb_o,
  output logic [15:0]       mode_o,
  output logic [31:0]       cmd_o,
  output logic              cmd_wstb_o,
  input  logic [31:0]       status_i
);
  localparam int unsigned WA_W   = ADDR_W - 2;
  localparam int unsigned RAM_AW = $clog2(RAM_DEPTH);

  logic            rd_req, wr_req, reg_hit, ram_sel;
  logic            rd_ack, wr_ack, rd_ack1, ram_we, ram_re;
  logic [WA_W-1:0] wadr;
  word_t           rd_dat_q, ram_q;

  wb_regbank_front #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .RAM_BASE(RAM_BASE)) u_front (
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i), .adr_i(wb_adr_i),
    .rd_ack_i(rd_ack), .wr_ack_i(wr_ack),
    .rd_req_o(rd_req), .wr_req_o(wr_req), .wadr_o(wadr),
    .reg_hit_o(reg_hit), .ram_sel_o(ram_sel),
    .ack_o(wb_ack_o), .stall_o(wb_stall_o)
  );

  wb_regbank_regs #(.WA_W(WA_W), .CTRL_PRESET(CTRL_PRESET), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_req_i(rd_req), .wr_req_i(wr_req), .wadr_i(wadr),
    .reg_hit_i(reg_hit), .ram_sel_i(ram_sel),
    .wdata_i(wb_dat_i), .status_i(status_i),
    .ctrl_o(ctrl_o), .ctrl_wstb_o(ctrl_wstb_o), .mode_o(mode_o),
    .cmd_o(cmd_o), .cmd_wstb_o(cmd_wstb_o),
    .wr_ack_o(wr_ack), .rd_ack1_o(rd_ack1), .rd_dat_o(rd_dat_q),
    .ram_we_o(ram_we)
  );

  wb_regbank_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .re_i(ram_re),
    .addr_i(wadr[RAM_AW-1:0]), .wdata_i(wb_dat_i), .rdata_o(ram_q)
  );

  // read mux: unmapped reads ack at once with zeros
  always_comb begin
    rd_ack   = rd_req;
    wb_dat_o = '0;
    ram_re   = 1'b0;
    if (reg_hit) begin
      wb_dat_o = rd_dat_q;
      rd_ack   = rd_ack1;
    end else if (ram_sel) begin
      wb_dat_o = ram_q;
      ram_re   = rd_req;
      rd_ack   = rd_ack1;
    end
  end

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && !reg_hit && !ram_sel |-> wb_ack_o && wb_dat_o == '0);
endmodule

// File: tb/sim_wb_regbank.sv
module sim_wb_regbank;
  localparam logic [31:0] PRESET = 32'h0000_00A5;
  localparam logic [31:0] IDV    = 32'h5EA1_0001;
  localparam logic [31:0] STAT   = 32'h0BAD_F00D;

  typedef struct packed {
    logic        we;
    logic [7:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h00, 32'h1234_5678, 32'h0, 2'd1},         // R2 ctrl write
    '{1'b0, 8'h00, 32'h0, 32'h1234_5678, 2'd1},         // R6 ctrl read
    '{1'b1, 8'h04, 32'hDEAD_BEEF, 32'h0, 2'd1},         // R2 mode write
    '{1'b0, 8'h04, 32'h0, 32'h0000_BEEF, 2'd1},         // R6 mode zero-extended
    '{1'b1, 8'h08, 32'hCAFE_F00D, 32'h0, 2'd1},         // R2 cmd write
    '{1'b0, 8'h08, 32'h0, 32'h0, 2'd1},                 // R7 cmd reads zero
    '{1'b0, 8'h0C, 32'h0, STAT, 2'd1},                  // R6 status
    '{1'b0, 8'h10, 32'h0, IDV, 2'd1},                   // R6 identity
    '{1'b1, 8'h40, 32'h1111_1111, 32'h0, 2'd2},         // R9 ram first word
    '{1'b1, 8'h7C, 32'h2222_0000, 32'h0, 2'd2},         // R9 ram last word
    '{1'b0, 8'h40, 32'h0, 32'h1111_1111, 2'd1},         // R9
    '{1'b0, 8'h7C, 32'h0, 32'h2222_0000, 2'd1},         // R9
    '{1'b0, 8'h20, 32'h0, 32'h0, 2'd0},                 // R8
    '{1'b0, 8'hFC, 32'h0, 32'h0, 2'd0},                 // R8
    '{1'b1, 8'h24, 32'h5555_5555, 32'h0, 2'd1}          // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0]  adr = '0;
  logic [31:0] dat = '0;
  logic [31:0] dat_o, ctrl, cmd;
  logic [15:0] mode;
  logic        ack, stall, ctrl_stb, cmd_stb;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  wb_regbank #(.ADDR_W(8), .RAM_DEPTH(16), .RAM_BASE(16),
               .CTRL_PRESET(PRESET), .ID_VALUE(IDV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .wb_stall_o(stall), .ctrl_o(ctrl), .ctrl_wstb_o(ctrl_stb), .mode_o(mode),
    .cmd_o(cmd), .cmd_wstb_o(cmd_stb), .status_i(STAT)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d;
    #1;
    lat = 0;
    if (!ack) begin
      lat = -1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (ack) begin lat = k; break; end
      end
    end
    rd = dat_o;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk("R1 ctrl in reset", ctrl, PRESET);
    chk("R1 ack in reset", {31'b0, ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl, PRESET);
    chk("R1 mode", {16'b0, mode}, 32'h0);
    chk("R1 cmd", cmd, 32'h0);
    chk("R1 strobes", {30'b0, ctrl_stb, cmd_stb}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(TBL[i].we, TBL[i].adr, TBL[i].dat, rd, lat);
      chk($sformatf("vec%0d latency", i), lat, 32'(TBL[i].lat));
      if (!TBL[i].we) chk($sformatf("vec%0d read data", i), rd, TBL[i].exp);
    end
    @(negedge clk);
    chk("R2 ctrl_o after write", ctrl, 32'h1234_5678);
    chk("R2 mode_o after write", {16'b0, mode}, 32'h0000_BEEF);
    chk("R2 cmd_o after write", cmd, 32'hCAFE_F00D);
    chk("R5 ctrl_o after unmapped write", ctrl, 32'h1234_5678);
    chk("R5 cmd_o after unmapped write", cmd, 32'hCAFE_F00D);

    // R2 stall in request cycle, R4 ctrl strobe single pulse
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 8'h00; dat = 32'h0F0F_0F0F;
    #1;
    chk("R2 stall before edge", {31'b0, stall}, 32'h1);
    chk("R2 ack before edge", {31'b0, ack}, 32'h0);
    @(negedge clk);
    chk("R2 ack after edge", {31'b0, ack}, 32'h1);
    chk("R2 stall after ack", {31'b0, stall}, 32'h0);
    chk("R4 ctrl strobe high", {31'b0, ctrl_stb}, 32'h1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R4 ctrl strobe low", {31'b0, ctrl_stb}, 32'h0);
    chk("R2 ctrl value", ctrl, 32'h0F0F_0F0F);

    // R3 held write: ack 1,0,1; R4 strobe follows
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 8'h08; dat = 32'hAAAA_0000;
    @(negedge clk);
    chk("R3 first ack", {31'b0, ack}, 32'h1);
    chk("R4 cmd strobe high", {31'b0, cmd_stb}, 32'h1);
    @(negedge clk);
    chk("R3 ack gap", {31'b0, ack}, 32'h0);
    chk("R4 cmd strobe low", {31'b0, cmd_stb}, 32'h0);
    @(negedge clk);
    chk("R3 second ack", {31'b0, ack}, 32'h1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    chk("R3 cmd value", cmd, 32'hAAAA_0000);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 ctrl after re-reset", ctrl, PRESET);
    chk("R1 cmd after re-reset", cmd, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    xfer(1'b0, 8'h04, 32'h0, rd, lat);
    chk("R1 mode read after re-reset", rd, 32'h0);
    finish_run();
  end
endmodule